// File: doc/BRIEF.md
# FM Sound Timer and Status Unit

This unit holds the two interval timers, the status byte and the write-busy guard of the host register port of an FM sound generator. A free-running prescaler divides the master clock into ticks of 144 cycles. Timer A is a 10-bit down-counter stepped once per tick. Timer B is an 8-bit down-counter stepped once every 16 ticks. When a timer is already at zero on a step, it reloads. If that timer's overflow-enable bit is set, it also raises a sticky status flag. The flag stays set until the matching clear bit in the control input is driven high.

The host first selects a register with an address strobe, together with a part select that picks one of two register banks. It then writes with a data strobe. A write that falls in the bank's address window and arrives while the port is idle is forwarded to the external register file as a one-cycle write enable. The enable carries the address, the part and the data. The accepted write starts a 17-cycle busy window. The write path has no back-pressure. A data write made while busy, or made with no valid selection, is dropped silently. The host is expected to poll status bit 7 before writing. The timer reload values and the control bits arrive as plain inputs from the register file.

Top module: `fm_timer_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `status` reads 0x00 and `reg_we` is low.
- R2: With `tmr_ctrl` bit 0 (run A) and bit 2 (flag-enable A) set, status bit 0 is set at the first tick. It is then set again every 144*(RA+1) cycles, where RA = {`ta_hi`, `ta_lo`} is 10 bits wide.
- R3: With `tmr_ctrl` bit 1 (run B) and bit 3 (flag-enable B) set, status bit 1 is set every 2304*(RB+1) cycles, where RB = `tb_val`. This holds whether or not Timer A runs.
- R4: With a timer's run bit set but its flag-enable bit clear, its status flag never sets.
- R5: With a timer's run bit clear, its status flag never sets.
- R6: While `tmr_ctrl` bit 4 (or bit 5) is high, status bit 0 (or bit 1) is cleared one cycle later and cannot be set. The clear wins over a simultaneous overflow.
- R7: An address strobe with `part_sel`=0 selects addresses 0x21..0xB6. With `part_sel`=1 it selects 0x30..0xB6. A following accepted data write pulses `reg_we` for one cycle, on the cycle after the strobe, with that address, part and data.
- R8: An address outside its window leaves nothing selected, and the next data write produces no `reg_we`.
- R9: Status bit 7 (busy) is high for exactly 17 cycles, starting on the cycle after an accepted data write.
- R10: A data write made while busy produces no `reg_we`, does not extend the busy window, and keeps the current selection.
- R11: An accepted write clears the selection, so a second data write with no new address strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Address strobe |
| data_wr | input | 1 | Data strobe |
| part_sel | input | 1 | Register bank: 0 first bank, 1 second bank |
| host_addr | input | 8 | Register address sampled on `addr_wr` |
| host_data | input | 8 | Write data sampled on `data_wr` |
| ta_hi | input | 8 | Timer A reload, upper 8 bits |
| ta_lo | input | 2 | Timer A reload, lower 2 bits |
| tb_val | input | 8 | Timer B reload |
| tmr_ctrl | input | 6 | Bit 0 run A, bit 1 run B, bit 2 flag-enable A, bit 3 flag-enable B, bit 4 clear flag A, bit 5 clear flag B |
| status | output | 8 | Bit 7 busy, bit 1 Timer B flag, bit 0 Timer A flag, other bits zero |
| reg_we | output | 1 | One-cycle write enable to the register file |
| reg_part | output | 1 | Bank of the forwarded write |
| reg_addr | output | 8 | Address of the forwarded write |
| reg_data | output | 8 | Data of the forwarded write |

## Verification
The timers are tried with a table of reload values: Timer A at the minimum, at values that use only the low field, only the high field, or both, and Timer B with Timer A both stopped and running. Measuring the interval between two flag sets separates an off-by-one in the reload, a wrong field join and a wrong divide ratio from the correct period. The control patterns with the run bit, the flag-enable bit or the clear bit held in each position separate gating of the counter from gating of the flag. The host port is tried at each window edge in both banks, with writes that land inside the busy window and with repeated data strobes, which separates a busy window that extends or leaks from one that is exact.

// File: rtl/fm_tmr_pkg.sv
package fm_tmr_pkg;
  localparam int TICK_CYC  = 144;
  localparam int B_DIV     = 16;
  localparam int BUSY_CYC  = 17;
  localparam int REG_W     = 8;
  localparam int TA_LO_W   = 2;
  localparam int CTRL_W    = 6;

  localparam int CB_RUN_A  = 0;
  localparam int CB_RUN_B  = 1;
  localparam int CB_FLG_A  = 2;
  localparam int CB_FLG_B  = 3;
  localparam int CB_CLR_A  = 4;
  localparam int CB_CLR_B  = 5;

  localparam logic [7:0] BANK0_LO = 8'h21;
  localparam logic [7:0] BANK1_LO = 8'h30;
  localparam logic [7:0] BANK_HI  = 8'hB6;
endpackage

// File: rtl/fm_tmr_prescale.sv
module fm_tmr_prescale #(
  parameter int TICK_CYC = 144,
  parameter int B_DIV    = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_a,
  output logic tick_b
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int BW = (B_DIV > 1) ? $clog2(B_DIV) : 1;

  logic [PW-1:0] presc;
  logic [BW-1:0] bdiv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
    end else if (presc == PW'(TICK_CYC - 1)) begin
      presc <= '0;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bdiv <= '0;
    end else if (tick_a) begin
      if (bdiv == BW'(B_DIV - 1)) bdiv <= '0;
      else                         bdiv <= bdiv + 1'b1;
    end
  end

  assign tick_a = (presc == '0);
  assign tick_b = tick_a && (bdiv == '0);

  AST_TICKB_ON_TICKA: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |-> tick_a);  // R3
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> !tick_a);  // R2
endmodule

// File: rtl/fm_tmr_down.sv
module fm_tmr_down #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] reload,
  input  logic         flag_en,
  input  logic         flag_clr,
  output logic         flag
);
  logic [W-1:0] cnt;
  logic         wrap;

  assign wrap = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (step) begin
      if (cnt == '0) cnt <= reload;
      else           cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end else if (wrap && flag_en) begin
      flag <= 1'b1;
    end
  end

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(wrap && flag_en && !flag_clr));  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));  // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !flag);  // R6
endmodule

// File: rtl/fm_host_port.sv
module fm_host_port #(
  parameter int         BUSY_CYC = 17,
  parameter int         REG_W    = 8,
  parameter logic [7:0] BANK0_LO = 8'h21,
  parameter logic [7:0] BANK1_LO = 8'h30,
  parameter logic [7:0] BANK_HI  = 8'hB6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  logic             data_wr,
  input  logic             part_sel,
  input  logic [REG_W-1:0] host_addr,
  input  logic [REG_W-1:0] host_data,
  output logic             busy,
  output logic             reg_we,
  output logic             reg_part,
  output logic [REG_W-1:0] reg_addr,
  output logic [REG_W-1:0] reg_data
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic              sel_valid;
  logic              sel_part;
  logic [REG_W-1:0]  sel_addr;
  logic [BUSY_W-1:0] busy_cnt;
  logic              in_win;
  logic              accept;

  always_comb begin
    if (part_sel)
      in_win = (host_addr >= REG_W'(BANK1_LO)) && (host_addr <= REG_W'(BANK_HI));
    else
      in_win = (host_addr >= REG_W'(BANK0_LO)) && (host_addr <= REG_W'(BANK_HI));
  end

  assign busy   = (busy_cnt != '0);
  assign accept = data_wr && sel_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_valid <= 1'b0;
      sel_part  <= 1'b0;
      sel_addr  <= '0;
    end else if (addr_wr) begin
      sel_valid <= in_win;
      sel_part  <= part_sel;
      sel_addr  <= host_addr;
    end else if (accept) begin
      sel_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (accept) begin
      busy_cnt <= BUSY_W'(BUSY_CYC);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_we   <= 1'b0;
      reg_part <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
    end else begin
      reg_we <= accept;
      if (accept) begin
        reg_part <= sel_part;
        reg_addr <= sel_addr;
        reg_data <= host_data;
      end
    end
  end

  AST_WE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> busy);  // R9
  AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> !reg_we);  // R10
  AST_SEL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !$past(addr_wr)) |-> !sel_valid);  // R11
  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr <= REG_W'(BANK_HI)) &&
               (reg_addr >= (reg_part ? REG_W'(BANK1_LO) : REG_W'(BANK0_LO))));  // R7
endmodule

// File: rtl/fm_timer_status.sv
module fm_timer_status
  import fm_tmr_pkg::*;
#(
  parameter int TICKS    = TICK_CYC,
  parameter int BDIV     = B_DIV,
  parameter int BUSY_LEN = BUSY_CYC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_wr,
  input  logic               data_wr,
  input  logic               part_sel,
  input  logic [REG_W-1:0]   host_addr,
  input  logic [REG_W-1:0]   host_data,
  input  logic [REG_W-1:0]   ta_hi,
  input  logic [TA_LO_W-1:0] ta_lo,
  input  logic [REG_W-1:0]   tb_val,
  input  logic [CTRL_W-1:0]  tmr_ctrl,
  output logic [7:0]         status,
  output logic               reg_we,
  output logic               reg_part,
  output logic [REG_W-1:0]   reg_addr,
  output logic [REG_W-1:0]   reg_data
);
  localparam int TA_W = REG_W + TA_LO_W;
  localparam int TB_W = REG_W;

  logic tick_a, tick_b;
  logic flag_a, flag_b;
  logic busy;

  fm_tmr_prescale #(.TICK_CYC(TICKS), .B_DIV(BDIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b)
  );

  fm_tmr_down #(.W(TA_W)) u_tmr_a (
    .clk(clk), .rst_n(rst_n),
    .step(tick_a && tmr_ctrl[CB_RUN_A]),
    .reload({ta_hi, ta_lo}),
    .flag_en(tmr_ctrl[CB_FLG_A]),
    .flag_clr(tmr_ctrl[CB_CLR_A]),
    .flag(flag_a)
  );

  fm_tmr_down #(.W(TB_W)) u_tmr_b (
    .clk(clk), .rst_n(rst_n),
    .step(tick_b && tmr_ctrl[CB_RUN_B]),
    .reload(tb_val),
    .flag_en(tmr_ctrl[CB_FLG_B]),
    .flag_clr(tmr_ctrl[CB_CLR_B]),
    .flag(flag_b)
  );

  fm_host_port #(
    .BUSY_CYC(BUSY_LEN), .REG_W(REG_W),
    .BANK0_LO(BANK0_LO), .BANK1_LO(BANK1_LO), .BANK_HI(BANK_HI)
  ) u_port (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(addr_wr), .data_wr(data_wr), .part_sel(part_sel),
    .host_addr(host_addr), .host_data(host_data),
    .busy(busy),
    .reg_we(reg_we), .reg_part(reg_part),
    .reg_addr(reg_addr), .reg_data(reg_data)
  );

  assign status = {busy, 5'b00000, flag_b, flag_a};

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (status == 8'h00) && !reg_we);  // R1
  AST_FLAG_A_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(tmr_ctrl[CB_RUN_A]));  // R5
endmodule

// File: tb/fm_timer_status_tb_top.sv
`timescale 1ns/1ps
module fm_timer_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_wr = 1'b0, data_wr = 1'b0, part_sel = 1'b0;
  logic [7:0] host_addr = '0, host_data = '0;
  logic [7:0] ta_hi = '0;
  logic [1:0] ta_lo = '0;
  logic [7:0] tb_val = '0;
  logic [5:0] tmr_ctrl = '0;
  logic [7:0] status;
  logic       reg_we, reg_part;
  logic [7:0] reg_addr, reg_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fm_timer_status dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
    .part_sel(part_sel), .host_addr(host_addr), .host_data(host_data),
    .ta_hi(ta_hi), .ta_lo(ta_lo), .tb_val(tb_val), .tmr_ctrl(tmr_ctrl),
    .status(status), .reg_we(reg_we), .reg_part(reg_part),
    .reg_addr(reg_addr), .reg_data(reg_data)
  );

  typedef struct packed {
    logic [5:0]  ctrl;
    logic [7:0]  hi;
    logic [1:0]  lo;
    logic [7:0]  tb;
    logic        fbit;
    logic [15:0] period;
  } tvec_t;

  localparam tvec_t TVECS [0:7] = '{
    '{6'h05, 8'h00, 2'd0, 8'h00, 1'b0, 16'd144},
    '{6'h05, 8'h01, 2'd3, 8'h00, 1'b0, 16'd1152},
    '{6'h05, 8'h00, 2'd2, 8'h00, 1'b0, 16'd432},
    '{6'h05, 8'h10, 2'd1, 8'h00, 1'b0, 16'd9504},
    '{6'h0A, 8'h00, 2'd0, 8'h00, 1'b1, 16'd2304},
    '{6'h0A, 8'h00, 2'd0, 8'h02, 1'b1, 16'd6912},
    '{6'h0F, 8'h00, 2'd1, 8'h05, 1'b1, 16'd13824},
    '{6'h0B, 8'h03, 2'd0, 8'h00, 1'b1, 16'd2304}
  };

  typedef struct packed {
    logic       part;
    logic [7:0] addr;
    logic       ok;
  } wvec_t;

  localparam wvec_t WVECS [0:7] = '{
    '{1'b0, 8'h20, 1'b0}, '{1'b0, 8'h21, 1'b1},
    '{1'b0, 8'hB6, 1'b1}, '{1'b0, 8'hB7, 1'b0},
    '{1'b1, 8'h2F, 1'b0}, '{1'b1, 8'h30, 1'b1},
    '{1'b1, 8'hB7, 1'b0}, '{1'b1, 8'h21, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_addr(input logic p, input logic [7:0] a);
    part_sel = p; host_addr = a; addr_wr = 1'b1;
    @(negedge clk);
    addr_wr = 1'b0;
  endtask

  task automatic do_data(input logic [7:0] d);
    host_data = d; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic restart(input logic [5:0] c, input logic [7:0] h,
                         input logic [1:0] l, input logic [7:0] b);
    rst_n = 1'b0;
    tmr_ctrl = c; ta_hi = h; ta_lo = l; tb_val = b;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic quiet_run(input string tag, input int bitn);
    int seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (status[bitn]) seen = 1;
      @(negedge clk);
    end
    chk(tag, seen, 0);
  endtask

  initial begin
    #1600000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", int'(status), 0);
    chk("R1 we in reset", int'(reg_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", int'(status), 0);

    // host port: accepted write and busy window
    do_addr(1'b0, 8'h24);
    do_data(8'h55);
    chk("R7 we", int'(reg_we), 1);
    chk("R7 addr", int'(reg_addr), 'h24);
    chk("R7 part", int'(reg_part), 0);
    chk("R7 data", int'(reg_data), 'h55);
    chk("R9 busy start", int'(status[7]), 1);
    @(negedge clk);
    chk("R7 we one cycle", int'(reg_we), 0);
    do_addr(1'b0, 8'h40);
    do_data(8'h77);
    chk("R10 write while busy dropped", int'(reg_we), 0);
    repeat (13) @(negedge clk);
    chk("R9 busy last cycle", int'(status[7]), 1);
    @(negedge clk);
    chk("R10 busy not extended", int'(status[7]), 0);
    do_data(8'h99);
    chk("R10 selection kept", int'(reg_we), 1);
    chk("R10 selection addr", int'(reg_addr), 'h40);
    repeat (18) @(negedge clk);
    do_data(8'h11);
    chk("R11 selection cleared", int'(reg_we), 0);
    repeat (18) @(negedge clk);

    // address windows in both banks
    for (int i = 0; i < 8; i++) begin
      do_addr(WVECS[i].part, WVECS[i].addr);
      do_data(WVECS[i].addr ^ 8'hA5);
      if (WVECS[i].ok) begin
        chk("R7 window accept", int'(reg_we), 1);
        chk("R7 window addr", int'(reg_addr), int'(WVECS[i].addr));
        chk("R7 window part", int'(reg_part), int'(WVECS[i].part));
      end else begin
        chk("R8 window reject", int'(reg_we), 0);
      end
      repeat (18) @(negedge clk);
    end

    // timer periods from the table
    for (int i = 0; i < 8; i++) begin
      int n;
      int b;
      b = int'(TVECS[i].fbit);
      restart(TVECS[i].ctrl, TVECS[i].hi, TVECS[i].lo, TVECS[i].tb);
      chk(b ? "R3 first flag" : "R2 first flag", int'(status[b]), 1);
      tmr_ctrl = TVECS[i].ctrl | (6'h10 << b);
      @(negedge clk);
      chk("R6 flag cleared", int'(status[b]), 0);
      tmr_ctrl = TVECS[i].ctrl;
      n = 1;
      while (!status[b] && n < int'(TVECS[i].period) + 50) begin
        @(negedge clk);
        n++;
      end
      chk(b ? "R3 period" : "R2 period", n, int'(TVECS[i].period));
    end

    // gating of counter and flag
    restart(6'h01, 8'h00, 2'd0, 8'h00);
    quiet_run("R4 A flag-enable off", 0);
    restart(6'h02, 8'h00, 2'd0, 8'h00);
    quiet_run("R4 B flag-enable off", 1);
    restart(6'h04, 8'h00, 2'd0, 8'h00);
    quiet_run("R5 A not running", 0);
    restart(6'h08, 8'h00, 2'd0, 8'h00);
    quiet_run("R5 B not running", 1);
    restart(6'h15, 8'h00, 2'd0, 8'h00);
    quiet_run("R6 clear held wins", 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule